// File: doc/BRIEF.md
# USB Device Endpoint Control Register Bank

This block holds the control and status words of a full-speed USB device controller: one 16-bit word per endpoint, a 7-bit device address and the base pointer of the buffer descriptor table in packet memory. Software reaches these words through a plain 16-bit register port. The write takes effect on the clock edge. The read is combinational from the byte offset. In each endpoint word, three kinds of write behaviour sit side by side:
- flags that software can only clear, by writing 0;
- fields that software flips, by writing 1;
- ordinary read/write fields.

The transaction engine drives the hardware side. It reports completed receptions and transmissions, marks received SETUP packets, flips data toggles and loads handshake status. It also presents incoming token fields. The bank compares these fields with the device address and with each endpoint's address field, and returns the index of the matching endpoint. The engine reads the table base directly.

No data stream crosses this block. All pins are plain control and status signals without valid/ready back-pressure: a software write and a hardware event are each accepted in the cycle they are presented.

Top module: `usb_ep_regbank`

## Requirements
- R1: After reset, every endpoint word, the device address and the table base read as 0x0000.
- R2: The two completion flags are bit 15 (receive) and bit 7 (transmit). A software write of 0 to either flag clears it. A write of 1 leaves it unchanged.
- R3: The following fields flip in each bit where software writes 1 and hold where it writes 0: receive toggle (bit 14), receive status (bits 13:12), transmit toggle (bit 6) and transmit status (bits 5:4).
- R4: The setup marker (bit 11) ignores software writes. Type (bits 10:9), kind (bit 8) and endpoint address (bits 3:0) take the written value.
- R5: A hardware completion sets the completion flag of its direction (hw_tx 0 = receive, 1 = transmit). If software writes 0 to that flag in the same cycle, the flag still ends up set.
- R6: A receive completion with hw_setup=1 sets the setup marker together with the receive completion flag. The next receive completion with hw_setup=0 clears the marker. A transmit completion leaves it alone.
- R7: A hardware event with hw_tog=1 flips the data toggle of its direction. An event with hw_stat_we=1 loads hw_stat into the status field of that direction.
- R8: A bus reset clears every endpoint field except the two completion flags, which keep their value. It also clears the device address.
- R9: match_hit is 1 when tok_valid is high, tok_addr equals the device address, and tok_ep equals the address field of some endpoint. match_idx gives the lowest such endpoint index, and is 0 on a miss.
- R10: Endpoint n sits at byte offset 4·n. The device address sits at 0x4C (bits 6:0). The table base sits at 0x50: bits 15:3 are stored, bits 2:0 read 0, and a bus reset leaves it unchanged. Other offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | USB bus reset (or forced reset), one-cycle pulse |
| sw_we | input | 1 | Software write strobe |
| sw_addr | input | 7 | Software byte offset |
| sw_wdata | input | 16 | Software write data |
| sw_rdata | output | 16 | Read data at sw_addr |
| hw_valid | input | 1 | Hardware event present |
| hw_idx | input | 3 | Endpoint addressed by the event |
| hw_tx | input | 1 | Event direction, 1 = transmit |
| hw_cmp | input | 1 | Transfer completed |
| hw_setup | input | 1 | Completed reception was a SETUP |
| hw_tog | input | 1 | Flip the data toggle of this direction |
| hw_stat_we | input | 1 | Load hw_stat into the status field |
| hw_stat | input | 2 | New handshake status |
| tok_valid | input | 1 | Token fields valid |
| tok_addr | input | 7 | Token device address |
| tok_ep | input | 4 | Token endpoint number |
| match_hit | output | 1 | Some endpoint accepts the token |
| match_idx | output | 3 | Index of the accepting endpoint |
| btable_base | output | 16 | Buffer table base, 8-byte aligned |

## Verification
The hardest case to reach is a completion that arrives in the same cycle as software clearing the same flag, because the outcome depends on the order in which the two updates are resolved. The stimulus presents a hardware receive completion and a software write of zeros to both flags on one clock edge. It then reads back that the receive flag is set and the transmit flag is cleared. The setup marker's life cycle is also driven in full: it is set, survives a flag clear and a transmit completion, and is then cleared by a plain reception. Endpoint address collisions are set up on purpose to check that the lowest index wins.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef struct packed {
    logic       ctr_rx;
    logic       dtog_rx;
    logic [1:0] stat_rx;
    logic       setup;
    logic [1:0] ep_type;
    logic       ep_kind;
    logic       ctr_tx;
    logic       dtog_tx;
    logic [1:0] stat_tx;
    logic [3:0] ea;
  } ep_word_t;

  localparam int WORD_W = $bits(ep_word_t);
endpackage

// File: rtl/ep_word_reg.sv
module ep_word_reg
  import usb_ep_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rst,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        ev_hit,
  input  logic        ev_tx,
  input  logic        ev_cmp,
  input  logic        ev_setup,
  input  logic        ev_tog,
  input  logic        ev_stat_we,
  input  logic [1:0]  ev_stat,
  output ep_word_t    q
);
  ep_word_t w, after_sw, nx;
  assign w = ep_word_t'(wr_data);

  always_comb begin
    after_sw = q;
    if (wr_en) begin
      after_sw.ctr_rx  = q.ctr_rx & w.ctr_rx;
      after_sw.ctr_tx  = q.ctr_tx & w.ctr_tx;
      after_sw.dtog_rx = q.dtog_rx ^ w.dtog_rx;
      after_sw.stat_rx = q.stat_rx ^ w.stat_rx;
      after_sw.dtog_tx = q.dtog_tx ^ w.dtog_tx;
      after_sw.stat_tx = q.stat_tx ^ w.stat_tx;
      after_sw.ep_type = w.ep_type;
      after_sw.ep_kind = w.ep_kind;
      after_sw.ea      = w.ea;
    end
    nx = after_sw;
    if (bus_rst) begin
      nx        = '0;
      nx.ctr_rx = after_sw.ctr_rx;
      nx.ctr_tx = after_sw.ctr_tx;
    end
    if (ev_hit) begin
      if (!ev_tx) begin
        if (ev_cmp) begin
          nx.ctr_rx = 1'b1;
          nx.setup  = ev_setup;
        end
        if (ev_tog)     nx.dtog_rx = ~nx.dtog_rx;
        if (ev_stat_we) nx.stat_rx = ev_stat;
      end else begin
        if (ev_cmp)     nx.ctr_tx  = 1'b1;
        if (ev_tog)     nx.dtog_tx = ~nx.dtog_tx;
        if (ev_stat_we) nx.stat_tx = ev_stat;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nx;
  end

  p_ctr_rx_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit && !ev_tx && ev_cmp |=> q.ctr_rx);
  p_ctr_tx_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit && ev_tx && ev_cmp |=> q.ctr_tx);
  p_ctr_keep_busrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst && !wr_en && !ev_hit |=>
      q.ctr_rx == $past(q.ctr_rx) && q.ctr_tx == $past(q.ctr_tx) &&
      q.ea == 4'd0 && q.stat_rx == 2'd0 && q.setup == 1'b0);
  p_setup_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !ev_hit && !bus_rst |=> $stable(q.setup));
  p_setup_with_ctr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q.setup) |-> q.ctr_rx);
endmodule

// File: rtl/ep_token_match.sv
module ep_token_match #(
  parameter int N_EP  = 8,
  parameter int IDX_W = $clog2(N_EP)
) (
  input  logic                 tok_valid,
  input  logic [6:0]           tok_addr,
  input  logic [3:0]           tok_ep,
  input  logic [6:0]           dev_addr,
  input  logic [N_EP-1:0][3:0] ea_vec,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (tok_valid && tok_addr == dev_addr) begin
      for (int i = N_EP - 1; i >= 0; i--) begin
        if (ea_vec[i] == tok_ep) begin
          hit = 1'b1;
          idx = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/usb_ep_regbank.sv
module usb_ep_regbank
  import usb_ep_pkg::*;
#(
  parameter int N_EP     = 8,
  parameter int ADDR_W   = 7,
  parameter int DADDR_OF = 'h4C,
  parameter int BTAB_OF  = 'h50,
  localparam int IDX_W   = $clog2(N_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              sw_we,
  input  logic [ADDR_W-1:0] sw_addr,
  input  logic [15:0]       sw_wdata,
  output logic [15:0]       sw_rdata,
  input  logic              hw_valid,
  input  logic [IDX_W-1:0]  hw_idx,
  input  logic              hw_tx,
  input  logic              hw_cmp,
  input  logic              hw_setup,
  input  logic              hw_tog,
  input  logic              hw_stat_we,
  input  logic [1:0]        hw_stat,
  input  logic              tok_valid,
  input  logic [6:0]        tok_addr,
  input  logic [3:0]        tok_ep,
  output logic              match_hit,
  output logic [IDX_W-1:0]  match_idx,
  output logic [15:0]       btable_base
);
  ep_word_t             ep_q [N_EP];
  logic [N_EP-1:0][3:0] ea_vec;
  logic [6:0]           dev_addr_q;
  logic [12:0]          btab_q;

  for (genvar g = 0; g < N_EP; g++) begin : g_ep
    ep_word_reg u_ep (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rst   (bus_reset),
      .wr_en     (sw_we && sw_addr == ADDR_W'(4 * g)),
      .wr_data   (sw_wdata),
      .ev_hit    (hw_valid && hw_idx == IDX_W'(g)),
      .ev_tx     (hw_tx),
      .ev_cmp    (hw_cmp),
      .ev_setup  (hw_setup),
      .ev_tog    (hw_tog),
      .ev_stat_we(hw_stat_we),
      .ev_stat   (hw_stat),
      .q         (ep_q[g])
    );
    assign ea_vec[g] = ep_q[g].ea;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || bus_reset)                          dev_addr_q <= '0;
    else if (sw_we && sw_addr == ADDR_W'(DADDR_OF))   dev_addr_q <= sw_wdata[6:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                       btab_q <= '0;
    else if (sw_we && sw_addr == ADDR_W'(BTAB_OF))    btab_q <= sw_wdata[15:3];
  end

  assign btable_base = {btab_q, 3'b000};

  always_comb begin
    sw_rdata = '0;
    for (int i = 0; i < N_EP; i++)
      if (sw_addr == ADDR_W'(4 * i)) sw_rdata = ep_q[i];
    if (sw_addr == ADDR_W'(DADDR_OF)) sw_rdata = {9'd0, dev_addr_q};
    if (sw_addr == ADDR_W'(BTAB_OF))  sw_rdata = btable_base;
  end

  ep_token_match #(.N_EP(N_EP), .IDX_W(IDX_W)) u_match (
    .tok_valid(tok_valid),
    .tok_addr (tok_addr),
    .tok_ep   (tok_ep),
    .dev_addr (dev_addr_q),
    .ea_vec   (ea_vec),
    .hit      (match_hit),
    .idx      (match_idx)
  );

  p_match_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> tok_valid && ea_vec[match_idx] == tok_ep && tok_addr == dev_addr_q);
  p_miss_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !match_hit |-> match_idx == '0);
  p_daddr_busrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> dev_addr_q == 7'd0);
  p_btab_busrst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset && !(sw_we && sw_addr == ADDR_W'(BTAB_OF)) |=> $stable(btab_q));
endmodule

// File: tb/sim_usb_ep_regbank.sv
`timescale 1ns/1ps
module sim_usb_ep_regbank;
  logic clk = 0, rst_n = 0, bus_reset = 0;
  logic sw_we = 0;
  logic [6:0] sw_addr = 0;
  logic [15:0] sw_wdata = 0, sw_rdata, btable_base;
  logic hw_valid = 0, hw_tx = 0, hw_cmp = 0, hw_setup = 0, hw_tog = 0, hw_stat_we = 0;
  logic [2:0] hw_idx = 0, match_idx;
  logic [1:0] hw_stat = 0;
  logic tok_valid = 0, match_hit;
  logic [6:0] tok_addr = 0;
  logic [3:0] tok_ep = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { bit is_match; logic [15:0] exp; string tag; } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  usb_ep_regbank u0 (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    sw_we = 1; sw_addr = a; sw_wdata = d;
    tick();
    sw_we = 0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [15:0] e, input string tag);
    item_t it;
    sw_addr = a;
    it.is_match = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    tick();
  endtask

  task automatic tok(input bit v, input logic [6:0] a, input logic [3:0] ep,
                     input bit ehit, input logic [2:0] eidx, input string tag);
    item_t it;
    tok_valid = v; tok_addr = a; tok_ep = ep;
    it.is_match = 1; it.exp = {12'd0, ehit, eidx}; it.tag = tag;
    sb.push_back(it);
    tick();
    tok_valid = 0;
  endtask

  task automatic ev(input logic [2:0] i, input bit tx, input bit cmp, input bit stp,
                    input bit tg, input bit swe, input logic [1:0] st);
    hw_valid = 1; hw_idx = i; hw_tx = tx; hw_cmp = cmp; hw_setup = stp;
    hw_tog = tg; hw_stat_we = swe; hw_stat = st;
    tick();
    hw_valid = 0; hw_cmp = 0; hw_setup = 0; hw_tog = 0; hw_stat_we = 0;
  endtask

  // monitor: compares outputs against queued expectations
  initial forever begin
    @(negedge clk); #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      act = it.is_match ? {12'd0, match_hit, match_idx} : sw_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    for (int i = 0; i < 8; i++) rd(7'(4 * i), 16'h0000, "R1 ep reset");
    rd(7'h4C, 16'h0000, "R1 daddr reset");
    rd(7'h50, 16'h0000, "R1 btable reset");
    tok(1, 7'h00, 4'h0, 1, 3'd0, "R9 reset token hits ep0");
    tok(0, 7'h00, 4'h0, 0, 3'd0, "R9 invalid token misses");
    // R2/R4: ones in flag and marker bits have no effect
    wr(7'h08, 16'h8D85);
    rd(7'h08, 16'h0505, "R2 R4 rw fields, flags and setup unaffected");
    // R3 toggles
    wr(7'h08, 16'hE5D5);
    rd(7'h08, 16'h6555, "R3 toggle set");
    wr(7'h08, 16'hD585);
    rd(7'h08, 16'h3555, "R3 toggle flip back");
    wr(7'h08, 16'h8585);
    rd(7'h08, 16'h3555, "R3 zeros hold");
    // R5 completions
    ev(3'd2, 0, 1, 0, 0, 0, 2'd0);
    rd(7'h08, 16'hB555, "R5 rx completion");
    ev(3'd2, 1, 1, 0, 0, 0, 2'd0);
    rd(7'h08, 16'hB5D5, "R5 tx completion");
    wr(7'h08, 16'h0585);
    rd(7'h08, 16'h35D5, "R2 clear rx flag, keep tx");
    // same-cycle hw set vs sw clear
    sw_we = 1; sw_addr = 7'h08; sw_wdata = 16'h0505;
    ev(3'd2, 0, 1, 0, 0, 0, 2'd0);
    sw_we = 0;
    rd(7'h08, 16'hB555, "R5 hw set beats sw clear");
    // R6 setup marker
    ev(3'd2, 0, 1, 1, 0, 0, 2'd0);
    rd(7'h08, 16'hBD55, "R6 setup with ctr_rx");
    wr(7'h08, 16'h0585);
    rd(7'h08, 16'h3D55, "R6 setup survives flag clear");
    ev(3'd2, 1, 1, 0, 0, 0, 2'd0);
    rd(7'h08, 16'h3DD5, "R6 tx completion keeps setup");
    ev(3'd2, 0, 1, 0, 0, 0, 2'd0);
    rd(7'h08, 16'hB5D5, "R6 plain rx clears setup");
    // R7 toggle and status from hardware
    ev(3'd2, 0, 0, 0, 1, 1, 2'b10);
    rd(7'h08, 16'hE5D5, "R7 rx toggle and status");
    ev(3'd2, 1, 0, 0, 1, 1, 2'b01);
    rd(7'h08, 16'hE595, "R7 tx toggle and status");
    // R10 address and table base
    wr(7'h4C, 16'hFFAA);
    rd(7'h4C, 16'h002A, "R10 daddr field");
    wr(7'h50, 16'hFFFF);
    rd(7'h50, 16'hFFF8, "R10 btable aligned");
    wr(7'h20, 16'h1234);
    rd(7'h20, 16'h0000, "R10 unmapped ignored");
    // R8 bus reset
    bus_reset = 1; tick(); bus_reset = 0;
    rd(7'h08, 16'h8080, "R8 only flags kept");
    rd(7'h4C, 16'h0000, "R8 daddr cleared");
    rd(7'h50, 16'hFFF8, "R10 btable kept over bus reset");
    // R9 matching
    wr(7'h4C, 16'h0011);
    wr(7'h0C, 16'h0007);
    wr(7'h14, 16'h0007);
    wr(7'h04, 16'h0004);
    tok(1, 7'h11, 4'h7, 1, 3'd3, "R9 lowest index wins");
    tok(1, 7'h10, 4'h7, 0, 3'd0, "R9 address mismatch");
    tok(1, 7'h11, 4'h4, 1, 3'd1, "R9 ep1 hit");
    tok(1, 7'h11, 4'h9, 0, 3'd0, "R9 no endpoint");
    tok(1, 7'h11, 4'h0, 1, 3'd0, "R9 ep0 hit");
    tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule